// File: doc/BRIEF.md
# Multiplexed Waveform Sampling Sequencer

This block sits between a bank of analogue multiplexers and the flash converters they share, on a readout board for long wire detectors. Each converter set serves 16 wire channels through two 8-input multiplexers. The two converters of a set run interleaved, so together they deliver one sample per strobe. The block drives the shared select code and reports which converter of the pair is due next. Each returned word is tagged with its wire channel and its sample index, so every channel is revisited once per slot.

A synchronous start opens an event window of a fixed number of samples per channel. Every set feeds its own output lane, and all lanes are tagged in lock step. When the last channel of the last sample has been emitted, a one-cycle done pulse is given. The block then ignores strobes until the next start. Converter words are treated as unsigned codes and passed through unchanged.

Top module: `mux_wave_sequencer`

## Requirements
- R1: After reset `out_valid`, `done`, `mux_sel`, `mux_phase`, `out_idx` and all lane tags and data are 0, and strobes given before the first start produce no output.
- R2: Within a slot the k-th accepted strobe (k = 0..15) uses converter phase k mod 2 and select code k div 2. `mux_sel` and `mux_phase` show the values the next strobe will use, so lane 0 tags run 0,8,1,9,2,10,...,7,15.
- R3: An accepted strobe gives `out_valid` high for exactly one cycle, in the following cycle, with each lane's 10-bit word passed through unchanged. Lane s takes bits [10s+9:10s] of `adc_data` and drives bits [10s+9:10s] of `out_data`.
- R4: `out_idx` holds the slot number, starting at 0. It increments only after all 16 strobes of a slot are accepted.
- R5: Lane s tags its sample with channel s*16 + phase*8 + select, in bits [5s+4:5s] of `out_chan`.
- R6: `done` is high for one cycle, together with the output of the final strobe of the window (index WINDOW-1, lane 0 channel 15). After that, strobes produce no output and `mux_sel` and `mux_phase` read 0 until a new start.
- R7: A start clears the select, phase and index, even in the middle of a window, so the next strobe is tagged channel 0, index 0. A strobe in the same cycle as start is ignored.
- R8: Idle cycles between strobes do not change the sequence, and `out_valid` is low in every cycle that does not follow an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new event window |
| adc_stb | input | 1 | One converter word per set is present |
| adc_data | input | NSETS*10 | Converter words, one per set |
| mux_sel | output | 3 | Select code shared by all multiplexers |
| mux_phase | output | 1 | Converter of the pair due next |
| out_valid | output | 1 | Tagged samples present |
| out_idx | output | log2(WINDOW) | Sample index within the window |
| out_chan | output | NSETS*5 | Channel tag per lane |
| out_data | output | NSETS*10 | Sample code per lane |
| done | output | 1 | Final sample of the window present |

## Verification
The bench builds the block with two sets and a window of 4 samples, so the test reaches the end of the window, the done pulse and the ignored strobes that follow in a few hundred cycles. With two sets, the second lane's offset of 16 is checked against the first lane on every strobe. Idle gaps in one slot, a restart in the middle of a window, and a start that coincides with a strobe cover the ordering corners.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  function automatic int unsigned bits_for(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
  import wseq_pkg::*;
#(
  parameter int unsigned MUX_IN      = 8,
  parameter int unsigned MUX_PER_SET = 2,
  parameter int unsigned WINDOW      = 1024,
  localparam int unsigned SELW = bits_for(MUX_IN),
  localparam int unsigned PHW  = bits_for(MUX_PER_SET),
  localparam int unsigned IDXW = bits_for(WINDOW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            adc_stb,
  output logic            take,
  output logic [SELW-1:0] sel,
  output logic [PHW-1:0]  phase,
  output logic            out_valid,
  output logic [IDXW-1:0] out_idx,
  output logic            done
);
  logic            active;
  logic [IDXW-1:0] idx;
  logic            ph_end, sel_end, idx_end, last;

  assign take    = adc_stb & active & ~start;
  assign ph_end  = (phase == PHW'(MUX_PER_SET - 1));
  assign sel_end = (sel == SELW'(MUX_IN - 1));
  assign idx_end = (idx == IDXW'(WINDOW - 1));
  assign last    = ph_end & sel_end & idx_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      phase     <= '0;
      sel       <= '0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= take;
      done      <= take & last;
      if (take) out_idx <= idx;
      if (start) begin
        active <= 1'b1;
        phase  <= '0;
        sel    <= '0;
        idx    <= '0;
      end else if (take) begin
        if (last) begin
          active <= 1'b0;
          phase  <= '0;
          sel    <= '0;
          idx    <= '0;
        end else if (!ph_end) begin
          phase <= phase + 1'b1;
        end else begin
          phase <= '0;
          if (!sel_end) begin
            sel <= sel + 1'b1;
          end else begin
            sel <= '0;
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  // R6
  done_with_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_valid && out_idx == IDXW'(WINDOW - 1)));
  // R6
  idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !out_valid);
  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> !out_valid);
  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (sel == '0 && phase == '0 && idx == '0 && !out_valid));
  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !(ph_end && sel_end)) |=> $stable(idx));
  // R2
  sel_step_chk: assert property (@(posedge clk) disable iff (rst)
    (take && ph_end && !sel_end) |=> (sel == $past(sel) + 1'b1 && phase == '0));
endmodule

// File: rtl/wseq_lane.sv
module wseq_lane
  import wseq_pkg::*;
#(
  parameter int unsigned SET         = 0,
  parameter int unsigned W           = 10,
  parameter int unsigned MUX_IN      = 8,
  parameter int unsigned MUX_PER_SET = 2,
  parameter int unsigned CHW         = 5,
  localparam int unsigned SELW   = bits_for(MUX_IN),
  localparam int unsigned PHW    = bits_for(MUX_PER_SET),
  localparam int unsigned PERSET = MUX_IN * MUX_PER_SET,
  localparam int unsigned BASE   = SET * PERSET
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            vld,
  input  logic [SELW-1:0] sel,
  input  logic [PHW-1:0]  phase,
  input  logic [W-1:0]    din,
  output logic [CHW-1:0]  chan_q,
  output logic [W-1:0]    data_q
);
  logic [CHW-1:0] chan_n;
  assign chan_n = CHW'(BASE + int'(phase) * MUX_IN + int'(sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      data_q <= '0;
    end else if (take) begin
      chan_q <= chan_n;
      data_q <= din;
    end
  end

  // R5
  chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    vld |-> (int'(chan_q) >= BASE && int'(chan_q) < BASE + PERSET));
endmodule

// File: rtl/mux_wave_sequencer.sv
module mux_wave_sequencer
  import wseq_pkg::*;
#(
  parameter int unsigned W           = 10,
  parameter int unsigned MUX_IN      = 8,
  parameter int unsigned MUX_PER_SET = 2,
  parameter int unsigned NSETS       = 2,
  parameter int unsigned WINDOW      = 1024,
  localparam int unsigned SELW = bits_for(MUX_IN),
  localparam int unsigned PHW  = bits_for(MUX_PER_SET),
  localparam int unsigned IDXW = bits_for(WINDOW),
  localparam int unsigned CHW  = bits_for(NSETS * MUX_PER_SET * MUX_IN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               adc_stb,
  input  logic [NSETS*W-1:0] adc_data,
  output logic [SELW-1:0]    mux_sel,
  output logic [PHW-1:0]     mux_phase,
  output logic               out_valid,
  output logic [IDXW-1:0]    out_idx,
  output logic [NSETS*CHW-1:0] out_chan,
  output logic [NSETS*W-1:0] out_data,
  output logic               done
);
  logic take;

  wseq_ctrl #(.MUX_IN(MUX_IN), .MUX_PER_SET(MUX_PER_SET), .WINDOW(WINDOW)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .adc_stb(adc_stb), .take(take),
    .sel(mux_sel), .phase(mux_phase), .out_valid(out_valid),
    .out_idx(out_idx), .done(done)
  );

  for (genvar s = 0; s < NSETS; s++) begin : g_lane
    wseq_lane #(.SET(s), .W(W), .MUX_IN(MUX_IN), .MUX_PER_SET(MUX_PER_SET),
                .CHW(CHW)) lane_i (
      .clk(clk), .rst(rst), .take(take), .vld(out_valid),
      .sel(mux_sel), .phase(mux_phase),
      .din(adc_data[s*W +: W]),
      .chan_q(out_chan[s*CHW +: CHW]),
      .data_q(out_data[s*W +: W])
    );
  end
endmodule

// File: tb/mux_wave_sequencer_tb_top.sv
module mux_wave_sequencer_tb_top;
  localparam int W = 10;
  localparam int NSETS = 2;
  localparam int WINDOW = 4;

  logic clk = 0, rst = 1, start = 0, adc_stb = 0;
  logic [NSETS*W-1:0] adc_data = '0;
  logic [2:0] mux_sel;
  logic mux_phase, out_valid, done;
  logic [1:0] out_idx;
  logic [NSETS*5-1:0] out_chan;
  logic [NSETS*W-1:0] out_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mux_wave_sequencer #(.NSETS(NSETS), .WINDOW(WINDOW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .adc_stb(adc_stb), .adc_data(adc_data),
    .mux_sel(mux_sel), .mux_phase(mux_phase), .out_valid(out_valid),
    .out_idx(out_idx), .out_chan(out_chan), .out_data(out_data), .done(done)
  );

  // {data[14:5], expected lane 0 channel[4:0]}
  localparam logic [14:0] TBL [16] = '{
    {10'd0,    5'd0},  {10'd1023, 5'd8},  {10'd1,   5'd1},  {10'd512, 5'd9},
    {10'd77,   5'd2},  {10'd300,  5'd10}, {10'd5,   5'd3},  {10'd999, 5'd11},
    {10'd128,  5'd4},  {10'd64,   5'd12}, {10'd33,  5'd5},  {10'd700, 5'd13},
    {10'd256,  5'd6},  {10'd511,  5'd14}, {10'd2,   5'd7},  {10'd1000,5'd15}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [9:0] d0, input bit with_start = 0);
    @(negedge clk);
    adc_stb = 1; start = with_start; adc_data = {~d0, d0};
    @(negedge clk);
    adc_stb = 0; start = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #160000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst = 0; idle(1);
    // R1 reset state
    check("R1 valid", out_valid, 0);
    check("R1 done", done, 0);
    check("R1 sel", mux_sel, 0);
    check("R1 phase", mux_phase, 0);
    check("R1 chan", out_chan, 0);
    check("R1 data", out_data, 0);
    strobe(10'd55);
    check("R1 strobe before start", out_valid, 0);

    pulse_start();
    for (int slot = 0; slot < WINDOW; slot++) begin
      for (int k = 0; k < 16; k++) begin
        logic [9:0] d;
        d = TBL[k][14:5];
        if (slot == 2) idle(3);  // R8 gaps
        check("R2 sel before strobe", mux_sel, k / 2);
        check("R2 phase before strobe", mux_phase, k % 2);
        strobe(d);
        check("R3 valid", out_valid, 1);
        check("R2 lane0 chan", out_chan[4:0], TBL[k][4:0]);
        check("R5 lane1 chan", out_chan[9:5], TBL[k][4:0] + 16);
        check("R3 lane0 data", out_data[9:0], d);
        check("R3 lane1 data", out_data[19:10], 10'(~d));
        check("R4 idx", out_idx, slot);
        check("R6 done", done, (slot == WINDOW - 1 && k == 15) ? 1 : 0);
        if (slot == 2) begin
          idle(1);
          check("R8 valid low in gap", out_valid, 0);
        end
      end
    end
    // R6 after done
    check("R6 sel after done", mux_sel, 0);
    strobe(10'd9);
    check("R6 strobe after done", out_valid, 0);
    check("R6 done one cycle", done, 0);

    // R7 restart mid window
    pulse_start();
    for (int k = 0; k < 21; k++) strobe(10'd3);
    check("R7 mid idx", out_idx, 1);
    pulse_start();
    check("R7 sel cleared", mux_sel, 0);
    strobe(10'd444);
    check("R7 chan after restart", out_chan[4:0], 0);
    check("R7 idx after restart", out_idx, 0);
    check("R7 data after restart", out_data[9:0], 444);

    // R7 strobe coinciding with start ignored
    strobe(10'd100);
    strobe(10'd200, 1);
    check("R7 start+strobe no valid", out_valid, 0);
    strobe(10'd300);
    check("R7 chan after start+strobe", out_chan[4:0], 0);
    check("R7 data after start+strobe", out_data[9:0], 300);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule